// File: doc/BRIEF.md
# Bus Error Capture Register

This block keeps a record of the first bus fault on a memory system that a processor and DMA engines share. The memory controller sends it fault reports. Each report is a one-cycle strobe that comes with a word address, the agent that issued the access, the access direction, and a flag that picks between an ECC fault and a timeout/overrun. When the record is empty, the block latches the report into a 32-bit status word. It then drives a level interrupt until software clears the record.

Some fields mean different things depending on the ECC flag. With the ECC flag clear, a set processor flag means a processor bus timeout, and a clear processor flag means a DMA overrun. With the ECC flag set, a set write flag means a partial memory write, and a clear write flag means a memory read. For an ECC read fault, the memory pipeline reports a word further along than the one that failed. The block stores the address with that skew applied: the low 12 bits are advanced by five words, wrapping inside the 4 KiB-word window, and the upper bits are kept as they are. Software gets the byte address by shifting the stored word address left by two. A register write clears the record, whatever data it carries. The block therefore has a write strobe and no data input.

Top module: `buserr_capture`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0 and the interrupt is low.
- R2: With the record empty, a fault strobe loads the status word on the next clock. The fields are bit 31 valid=1, bit 30 processor agent (1) or DMA (0), bit 29 write (1) or read (0), and bit 28 ECC fault (1) or timeout/overrun (0).
- R3: For a non-ECC fault, or for an ECC fault on a write, bits 27:0 hold the reported word address unchanged.
- R4: For an ECC fault on a read, bits 27:12 hold the reported address bits unchanged, and bits 11:0 hold (reported bits 11:0 + 5) mod 4096.
- R5: While the record is valid and no write is requested, further fault strobes leave the status word unchanged.
- R6: A register write with no fault strobe in the same cycle makes the status word read 0 on the next clock, and the interrupt falls with it.
- R7: A register write and a fault strobe in the same cycle leave the new fault captured, including when the record was already valid.
- R8: The interrupt output equals status bit 31 in every cycle.
- R9: With no strobe and no write, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_strobe | input | 1 | One-cycle fault report from the memory controller |
| err_word_addr | input | 28 | Word address of the failing access |
| err_cpu | input | 1 | 1 = processor access, 0 = DMA |
| err_write | input | 1 | 1 = write access, 0 = read |
| err_ecc | input | 1 | 1 = ECC fault, 0 = timeout or overrun |
| csr_wr | input | 1 | Register write strobe; any write clears the record |
| csr_rdata | output | 32 | Status word |
| irq | output | 1 | Level interrupt, high while the record is valid |

## Verification
Some properties are checked on every clock:
- the interrupt tracks the valid bit;
- the flag fields and address are captured one cycle after an accepted strobe;
- the upper address bits survive the skew adjustment;
- the word is frozen while valid and uncleared;
- a lone write clears the word to zero.

Other behaviour shows up only in the bench scenarios, where a cycle-level reference model computes the expected word for each of them:
- the exact skewed low bits, including the wrap at the top of the 4 KiB-word window;
- the same-cycle clear-and-capture race on a record that is already valid;
- the reset value.

// File: rtl/buserr_pkg.sv
// Package: field positions and flag bundle shared by the bus error capture
// logic. Assumes a 32-bit status word with four flags above the address.
package buserr_pkg;

    localparam int FLAG_BITS = 4;
    localparam int VALID_POS = 31;
    localparam int CPU_POS   = 30;
    localparam int WRITE_POS = 29;
    localparam int ECC_POS   = 28;

    // Flag bundle in the order the status word stores it (MSB first).
    typedef struct packed {
        logic valid;
        logic cpu;
        logic write;
        logic ecc;
    } err_flags_t;

    // True when the report needs the pipeline skew on its address.
    function automatic logic needs_skew(input logic ecc, input logic write);
        return ecc & ~write;
    endfunction

endpackage

// File: rtl/buserr_addr_adjust.sv
// Module: applies the pipeline skew to the reported word address.
// For ECC read faults, the low WIN_BITS bits are advanced by SKEW, wrapping
// inside the window, and the upper bits pass through. All other faults pass
// through unchanged. Purely combinational.
module buserr_addr_adjust #(
    parameter int ADDR_W   = 28,
    parameter int WIN_BITS = 12,
    parameter int SKEW     = 5
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              apply,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [WIN_BITS-1:0] SKEW_V = WIN_BITS'(SKEW);

    logic [WIN_BITS-1:0] low_sum;

    // Advance the low window by the skew, with modulo wrap.
    always_comb low_sum = addr_in[WIN_BITS-1:0] + SKEW_V;

    generate
        if (WIN_BITS < ADDR_W) begin : g_split
            // Keep the upper bits and splice in the adjusted window.
            always_comb addr_out = apply ? {addr_in[ADDR_W-1:WIN_BITS], low_sum} : addr_in;
        end else begin : g_full
            // The window covers the whole address.
            always_comb addr_out = apply ? low_sum : addr_in;
        end
    endgenerate
endmodule

// File: rtl/buserr_record.sv
// Module: holds the captured fault record.
// Capture takes priority over clear, so a strobe in a clearing cycle wins.
// A clear with no capture zeroes the whole record. Synchronous active-low reset.
module buserr_record #(
    parameter int ADDR_W = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic                 clear,
    input  buserr_pkg::err_flags_t flags_in,
    input  logic [ADDR_W-1:0]    addr_in,
    output buserr_pkg::err_flags_t flags_q,
    output logic [ADDR_W-1:0]    addr_q
);
    // Record register: reset, capture, clear, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            addr_q  <= '0;
        end else if (capture) begin
            flags_q <= flags_in;
            addr_q  <= addr_in;
        end else if (clear) begin
            flags_q <= '0;
            addr_q  <= '0;
        end
    end
endmodule

// File: rtl/buserr_capture.sv
// Module: top of the bus error capture register.
// It accepts a fault report when the record is empty or being cleared in the
// same cycle, skews the ECC-read address, and exposes the status word and a
// level interrupt. Assumes ADDR_W + 4 == 32 and fault strobes one cycle wide.
module buserr_capture #(
    parameter int ADDR_W   = 28,
    parameter int WIN_BITS = 12,
    parameter int SKEW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_strobe,
    input  logic [ADDR_W-1:0] err_word_addr,
    input  logic              err_cpu,
    input  logic              err_write,
    input  logic              err_ecc,
    input  logic              csr_wr,
    output logic [ADDR_W+3:0] csr_rdata,
    output logic              irq
);
    import buserr_pkg::*;

    err_flags_t        new_flags;
    err_flags_t        held_flags;
    logic [ADDR_W-1:0] adj_addr;
    logic [ADDR_W-1:0] held_addr;
    logic              accept;

    // Accept a report when nothing is held or the held record is being cleared.
    always_comb accept = err_strobe & (~held_flags.valid | csr_wr);

    // Build the flag bundle of the incoming report.
    always_comb begin
        new_flags.valid = 1'b1;
        new_flags.cpu   = err_cpu;
        new_flags.write = err_write;
        new_flags.ecc   = err_ecc;
    end

    buserr_addr_adjust #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS),
        .SKEW    (SKEW)
    ) u_adj (
        .addr_in (err_word_addr),
        .apply   (needs_skew(err_ecc, err_write)),
        .addr_out(adj_addr)
    );

    buserr_record #(
        .ADDR_W(ADDR_W)
    ) u_rec (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept),
        .clear   (csr_wr),
        .flags_in(new_flags),
        .addr_in (adj_addr),
        .flags_q (held_flags),
        .addr_q  (held_addr)
    );

    // Drive the status word and the level interrupt from the held record.
    always_comb begin
        csr_rdata = {held_flags, held_addr};
        irq       = held_flags.valid;
    end
endmodule

// File: rtl/buserr_capture_chk.sv
// Checker: temporal properties of the bus error capture register, bound to
// the top module. Observes ports only.
module buserr_capture_chk #(
    parameter int ADDR_W   = 28,
    parameter int WIN_BITS = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              err_strobe,
    input logic [ADDR_W-1:0] err_word_addr,
    input logic              err_cpu,
    input logic              err_write,
    input logic              err_ecc,
    input logic              csr_wr,
    input logic [ADDR_W+3:0] csr_rdata,
    input logic              irq
);
    logic take;
    always_comb take = err_strobe & (~irq | csr_wr);

    // R8
    p_irq_tracks_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq == csr_rdata[ADDR_W+3]);

    // R2 and R7
    p_flags_captured_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> csr_rdata[ADDR_W+3:ADDR_W] ==
                 {1'b1, $past(err_cpu), $past(err_write), $past(err_ecc)});

    // R3
    p_addr_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(err_ecc && !err_write)) |=> csr_rdata[ADDR_W-1:0] == $past(err_word_addr));

    // R4: the upper part is untouched by the skew
    p_skew_upper_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && err_ecc && !err_write) |=>
            csr_rdata[ADDR_W-1:WIN_BITS] == $past(err_word_addr[ADDR_W-1:WIN_BITS]));

    // R5
    p_first_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !csr_wr) |=> $stable(csr_rdata));

    // R6
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !err_strobe) |=> (csr_rdata == '0 && !irq));

    // R7
    p_race_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && err_strobe) |=> irq);

    // R9
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_strobe && !csr_wr) |=> $stable(csr_rdata));
endmodule

bind buserr_capture buserr_capture_chk #(
    .ADDR_W  (ADDR_W),
    .WIN_BITS(WIN_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_strobe   (err_strobe),
    .err_word_addr(err_word_addr),
    .err_cpu      (err_cpu),
    .err_write    (err_write),
    .err_ecc      (err_ecc),
    .csr_wr       (csr_wr),
    .csr_rdata    (csr_rdata),
    .irq          (irq)
);

// File: tb/sim_buserr_capture.sv
// Bench: drives fault reports and clears, and compares the outputs with a
// behavioural reference model every clock, half a period after the edge.
module sim_buserr_capture;
    localparam int AW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          err_strobe = 1'b0;
    logic [AW-1:0] err_word_addr = '0;
    logic          err_cpu = 1'b0;
    logic          err_write = 1'b0;
    logic          err_ecc = 1'b0;
    logic          csr_wr = 1'b0;
    logic [31:0]   csr_rdata;
    logic          irq;

    int      n_cmp = 0;
    int      n_bad = 0;
    int      cycles = 0;
    bit      finished = 1'b0;
    string   tag = "R1";
    logic [31:0] model = 32'h0;

    always #4 clk = ~clk;   // 125 MHz

    buserr_capture u0 (
        .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe),
        .err_word_addr(err_word_addr), .err_cpu(err_cpu),
        .err_write(err_write), .err_ecc(err_ecc), .csr_wr(csr_wr),
        .csr_rdata(csr_rdata), .irq(irq)
    );

    // Reference model: the status word worked out from the requirements.
    always @(posedge clk) begin
        longint a;
        a = longint'(err_word_addr);
        if (err_ecc && !err_write)
            a = (a & ~longint'('hFFF)) | ((a + 5) & 'hFFF);
        if (!rst_n)
            model <= 32'h0;
        else if (err_strobe && (!model[31] || csr_wr))
            model <= {1'b1, err_cpu, err_write, err_ecc, a[27:0]};
        else if (csr_wr)
            model <= 32'h0;
    end

    // Compare the outputs with the model every clock, away from the edge.
    always @(negedge clk) begin
        if (!finished) begin
            cycles++;
            n_cmp++;
            if (csr_rdata !== model || irq !== model[31]) begin
                n_bad++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         tag, csr_rdata, irq, model, model[31]);
            end
            if (cycles > 100000) begin
                n_bad++;
                $display("FAIL watchdog: cycles=%0d expected <= 100000", cycles);
                finished = 1'b1;
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    // Drive one cycle of stimulus from a falling edge.
    task automatic step(input string t, input bit s, input logic [AW-1:0] a,
                        input bit c, input bit w, input bit e, input bit clr);
        tag = t;
        err_strobe = s; err_word_addr = a; err_cpu = c;
        err_write = w; err_ecc = e; csr_wr = clr;
        @(negedge clk);
        err_strobe = 1'b0; csr_wr = 1'b0;
    endtask

    // Explicit check of an expected word, with the requirement named.
    task automatic expect_word(input string t, input logic [31:0] exp);
        n_cmp++;
        if (csr_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected %h", t, csr_rdata, exp);
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        expect_word("R1", 32'h0);
        rst_n = 1'b1;
        step("R9", 0, 28'h0, 0, 0, 0, 0);
        expect_word("R9", 32'h0);
        // R3: processor read timeout
        step("R3", 1, 28'hABCDEF1, 1, 0, 0, 0);
        expect_word("R3", 32'hCABCDEF1);
        // R5: later fault ignored while valid
        step("R5", 1, 28'h1111111, 0, 1, 1, 0);
        expect_word("R5", 32'hCABCDEF1);
        step("R9", 0, 28'h0, 0, 0, 0, 0);
        // R6: clear
        step("R6", 0, 28'h0, 0, 0, 0, 1);
        expect_word("R6", 32'h0);
        // R4: ECC read with wrap at the window top
        step("R4", 1, 28'h1234FFD, 0, 0, 1, 0);
        expect_word("R4", 32'h91234002);
        // R7: clear racing a new DMA overrun on a valid record
        step("R7", 1, 28'h0765432, 0, 1, 0, 1);
        expect_word("R7", 32'hA0765432);
        step("R6", 0, 28'h0, 0, 0, 0, 1);
        // R2: ECC partial write by the processor, address not skewed
        step("R2", 1, 28'hFFFFFFF, 1, 1, 1, 0);
        expect_word("R2", 32'hFFFFFFFF);
        step("R6", 0, 28'h0, 0, 0, 0, 1);
        // R4: ECC read without wrap, processor agent
        step("R4", 1, 28'h0000100, 1, 0, 1, 0);
        expect_word("R4", 32'hD0000105);
        // R8: interrupt follows valid after clear
        step("R8", 0, 28'h0, 0, 0, 0, 1);
        n_cmp++;
        if (irq !== 1'b0) begin
            n_bad++;
            $display("FAIL R8: irq=%b expected 0", irq);
        end
        // R7: strobe and clear on an empty record
        step("R7", 1, 28'h0000ABC, 0, 0, 1, 1);
        expect_word("R7", 32'h90000AC1);
        step("R9", 0, 28'h0, 0, 0, 0, 0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule